// File: doc/BRIEF.md
# Serial Gain Word Receiver

This block takes gain settings for a four-channel amplifier over three wires: a serial clock, a serial data line and a latch strobe. Each setting is an 8-bit word sent most significant bit first. Data is taken on each rising edge of the serial clock. When the strobe reaches its active edge, the last eight bits received are decoded. If the word is valid and addressed to this device, its 4-bit gain code goes into the register of the channel the word names.

A static chip-select strap lets two receivers share the same serial lines. A word is accepted only when its enable bit is 1 and its select bit matches the strap. All three serial inputs are brought into the system clock domain through synchronizers. Edges are found there by comparing each synchronized level with its value one cycle earlier. For this to work, the serial clock must run slower than a quarter of the system clock.

The receiver drives one 4-bit code per channel and one flag per channel. The flag shows that the channel is switched off, which is code zero.

Top module: `gain_word_rx`

## Requirements
- R1: While reset is asserted, and after it is released, every channel holds code 4'b1000 (the 0 dB midpoint) and every off flag is 0, so gain_code reads 16'h8888.
- R2: The receiver samples serial data on each rising serial clock edge and shifts it in most significant bit first. At a latch, only the last eight bits received are decoded, and any earlier bits are ignored.
- R3: A word is committed only on the falling edge of the active-high latch strobe, which is the default polarity. Shifting bits and the rising edge of the strobe leave every channel unchanged.
- R4: A word whose bit 7 (the enable bit) is 0 is discarded, and no channel changes.
- R5: A word is accepted only when its bit 6 equals the chip_sel input. A word with the other value of bit 6 leaves every channel unchanged.
- R6: Bits 5:4 of an accepted word select the channel: 00 selects channel 0, 01 channel 1, 10 channel 2 and 11 channel 3. Bits 3:0 become that channel's code, and the other channels keep their codes.
- R7: chan_off[k] is 1 exactly when channel k holds code 4'b0000, and it returns to 0 once a nonzero code is written to that channel.
- R8: Channel k's code appears on gain_code[4k+3:4k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk | input | 1 | Serial bit clock, asynchronous to clk |
| ser_dat | input | 1 | Serial data, most significant bit first |
| latch_in | input | 1 | Latch strobe; the default build commits on its falling edge |
| chip_sel | input | 1 | Static strap that bit 6 of a word must match |
| gain_code | output | 16 | Four packed 4-bit channel codes, with channel 0 in the low nibble |
| chan_off | output | 4 | Per-channel flag that the channel is switched off (code 0) |

## Verification
The bench builds the block with its default parameters: four channels, 4-bit codes, two synchronizer stages and a strobe that commits on its falling edge. With these values, the stimulus can address every channel and write the zero code and the full-scale code. It also drives both strap values and sends words that carry extra leading bits. The serial clock runs at one eighth of the system clock. This leaves the synchronizer latency well inside each serial half period, so each latch can be checked a fixed number of cycles after the strobe edge.

// File: rtl/gain_rx_pkg.sv
package gain_rx_pkg;

    typedef enum logic {
        LATCH_ON_FALL = 1'b0,
        LATCH_ON_RISE = 1'b1
    } latch_edge_e;

    function automatic int unsigned chan_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.pipe[STAGES-1];

endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_lvl,
    input  logic              sdat_lvl,
    output logic [WORD_W-1:0] word
);
    typedef struct packed {
        logic              prev;
        logic [WORD_W-1:0] sr;
    } shf_st_t;

    shf_st_t st_d, st_q;
    logic    sclk_rise;

    assign sclk_rise = sclk_lvl & ~st_q.prev;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sclk_lvl;
        if (sclk_rise) begin
            st_d.sr = {st_q.sr[WORD_W-2:0], sdat_lvl};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word = st_q.sr;

    // R2: a serial rising edge takes the data bit into the bottom of the register
    p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_lvl && !st_q.prev) |=> (st_q.sr[0] == $past(sdat_lvl)));

    // R2: the register does not move without a serial rising edge
    p_shift_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_lvl && !st_q.prev) |=> $stable(st_q.sr));

endmodule

// File: rtl/gain_bank.sv
module gain_bank #(
    parameter int NUM_CH = 4,
    parameter int GAIN_W = 4,
    parameter int CH_W   = 2,
    parameter int WORD_W = 8,
    parameter gain_rx_pkg::latch_edge_e LATCH_EDGE = gain_rx_pkg::LATCH_ON_FALL
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           latch_lvl,
    input  logic [WORD_W-1:0]              word,
    input  logic                           cs,
    output logic [NUM_CH-1:0][GAIN_W-1:0]  gain,
    output logic [NUM_CH-1:0]              off
);
    localparam int EN_BIT = WORD_W - 1;
    localparam int CS_BIT = WORD_W - 2;
    localparam logic [GAIN_W-1:0] MID_CODE = GAIN_W'(1 << (GAIN_W - 1));
    localparam logic LAT_IDLE = (LATCH_EDGE == gain_rx_pkg::LATCH_ON_RISE);

    typedef struct packed {
        logic                          lat_prev;
        logic [NUM_CH-1:0][GAIN_W-1:0] gain;
        logic [NUM_CH-1:0]             off;
    } bank_st_t;

    bank_st_t          st_d, st_q;
    logic              fire;
    logic              accept;
    logic [CH_W-1:0]   sel;

    generate
        if (LATCH_EDGE == gain_rx_pkg::LATCH_ON_FALL) begin : g_fall
            assign fire = st_q.lat_prev & ~latch_lvl;
        end else begin : g_rise
            assign fire = ~st_q.lat_prev & latch_lvl;
        end
    endgenerate

    assign accept = fire & word[EN_BIT] & (word[CS_BIT] == cs);
    assign sel    = word[GAIN_W +: CH_W];

    always_comb begin
        st_d          = st_q;
        st_d.lat_prev = latch_lvl;
        for (int i = 0; i < NUM_CH; i++) begin
            if (accept && (sel == CH_W'(i))) begin
                st_d.gain[i] = word[GAIN_W-1:0];
            end
            st_d.off[i] = (st_d.gain[i] == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lat_prev <= LAT_IDLE;
            for (int i = 0; i < NUM_CH; i++) begin
                st_q.gain[i] <= MID_CODE;
            end
            st_q.off <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gain = st_q.gain;
    assign off  = st_q.off;

    // R3: without a latch edge no channel register moves
    p_no_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(st_q.gain));

    // R3: a latch edge is a single-cycle event
    p_edge_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

    // R4: disabled words change nothing
    p_discard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !word[EN_BIT]) |=> $stable(st_q.gain));

    // R5: words for the other device change nothing
    p_cs_mismatch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (word[CS_BIT] != cs)) |=> $stable(st_q.gain));

    generate
        for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
            // R6: the addressed channel takes the code
            p_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (accept && (sel == CH_W'(k))) |=> (st_q.gain[k] == $past(word[GAIN_W-1:0])));
            // R6: the other channels keep theirs
            p_others_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (accept && (sel != CH_W'(k))) |=> $stable(st_q.gain[k]));
            // R7: the off flag rises only onto a zero code
            p_off_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(st_q.off[k]) |-> (st_q.gain[k] == '0));
            // R7: the off flag falls only onto a nonzero code
            p_off_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(st_q.off[k]) |-> (st_q.gain[k] != '0));
        end
    endgenerate

endmodule

// File: rtl/gain_word_rx.sv
module gain_word_rx #(
    parameter int NUM_CH      = 4,
    parameter int GAIN_W      = 4,
    parameter int SYNC_STAGES = 2,
    parameter gain_rx_pkg::latch_edge_e LATCH_EDGE = gain_rx_pkg::LATCH_ON_FALL
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_clk,
    input  logic                     ser_dat,
    input  logic                     latch_in,
    input  logic                     chip_sel,
    output logic [NUM_CH*GAIN_W-1:0] gain_code,
    output logic [NUM_CH-1:0]        chan_off
);
    localparam int CH_W   = gain_rx_pkg::chan_bits(NUM_CH);
    localparam int WORD_W = 2 + CH_W + GAIN_W;

    logic [2:0]                    sync_v;
    logic [WORD_W-1:0]             word;
    logic [NUM_CH-1:0][GAIN_W-1:0] gain_arr;

    bit_sync #(
        .WIDTH (3),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({latch_in, ser_dat, ser_clk}),
        .dout (sync_v)
    );

    word_shifter #(
        .WORD_W(WORD_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_lvl(sync_v[0]),
        .sdat_lvl(sync_v[1]),
        .word    (word)
    );

    gain_bank #(
        .NUM_CH    (NUM_CH),
        .GAIN_W    (GAIN_W),
        .CH_W      (CH_W),
        .WORD_W    (WORD_W),
        .LATCH_EDGE(LATCH_EDGE)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_lvl(sync_v[2]),
        .word     (word),
        .cs       (chip_sel),
        .gain     (gain_arr),
        .off      (chan_off)
    );

    // R8: channel k occupies nibble k of the flat output
    assign gain_code = gain_arr;

endmodule

// File: tb/gain_word_rx_tb.sv
module gain_word_rx_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        latch_in = 1'b0;
    logic        chip_sel = 1'b0;
    logic [15:0] gain_code;
    logic [3:0]  chan_off;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [15:0] g;
        logic [3:0]  o;
        string       tag;
    } item_t;

    item_t      sb_q[$];
    logic [3:0] exp_gain[4];

    always #4 clk = ~clk;

    gain_word_rx u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_dat  (ser_dat),
        .latch_in (latch_in),
        .chip_sel (chip_sel),
        .gain_code(gain_code),
        .chan_off (chan_off)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] expv, input string tag);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [15:0] v, input int n);
        for (int b = n - 1; b >= 0; b--) begin
            ser_dat = v[b];
            ser_clk = 1'b0;
            tick(4);
            ser_clk = 1'b1;
            tick(4);
        end
        ser_clk = 1'b0;
        tick(4);
    endtask

    task automatic apply(input logic [7:0] w);
        if (w[7] && (w[6] == chip_sel)) exp_gain[w[5:4]] = w[3:0];
    endtask

    task automatic push(input string tag);
        item_t it;
        for (int c = 0; c < 4; c++) begin
            it.g[c*4 +: 4] = exp_gain[c];
            it.o[c]        = (exp_gain[c] == 4'b0000);
        end
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic latch_pulse();
        latch_in = 1'b1;
        tick(4);
        latch_in = 1'b0;
    endtask

    task automatic send(input logic [7:0] w, input string tag);
        shift_bits({8'h00, w}, 8);
        latch_pulse();
        apply(w);
        push(tag);
        tick(24);
    endtask

    // monitor: compare each expected item a fixed delay after its latch edge
    initial begin
        forever begin
            item_t it;
            wait (sb_q.size() != 0);
            it = sb_q.pop_front();
            repeat (10) @(posedge clk);
            #1;
            check(gain_code, it.g, {it.tag, " gain"});
            check({12'h000, chan_off}, {12'h000, it.o}, {it.tag, " off R7"});
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 4; c++) exp_gain[c] = 4'b1000;
        tick(5);
        check(gain_code, 16'h8888, "R1 gain in reset");
        rst_n = 1'b1;
        tick(3);
        check(gain_code, 16'h8888, "R1 gain after reset");
        check({12'h000, chan_off}, 16'h0000, "R1 off after reset");

        send(8'b1_0_00_1011, "R6 R8 ch0 write");
        send(8'b1_0_01_0000, "R7 ch1 off");
        send(8'b1_0_10_1111, "R6 ch2 full scale");
        send(8'b1_0_11_0001, "R6 ch3 lowest step");
        send(8'b0_0_00_0010, "R4 enable clear");
        send(8'b1_1_01_0110, "R5 select mismatch cs0");

        chip_sel = 1'b1;
        tick(8);
        send(8'b1_1_00_0101, "R5 select match cs1");
        send(8'b1_0_10_0011, "R5 select mismatch cs1");

        // R2: four leading bits, then the word; only the last eight count
        shift_bits(16'h06FC, 12);
        latch_pulse();
        apply(8'hFC);
        push("R2 extra leading bits");
        tick(24);

        // R3: shifting and the strobe rising leave the channels unchanged
        shift_bits(16'h00E8, 8);
        latch_in = 1'b1;
        push("R3 strobe high no commit");
        tick(16);
        latch_in = 1'b0;
        apply(8'hE8);
        push("R3 falling edge commits");
        tick(24);

        send(8'b1_1_01_1000, "R7 ch1 back on");

        wait (sb_q.size() == 0);
        repeat (14) @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule